// File: doc/BRIEF.md
# Synchronous Burst SRAM Port

This block is one clocked access port onto a small internal RAM array, by default 256 words of 9 bits. A write or a read is decided at each rising clock edge from two chip selects of opposite polarity and a read/write select. The address of each access comes from an on-chip burst counter. At every edge the counter can be cleared, loaded from the external address bus, held, or advanced by one. Because of this, a burst needs only one address load and then one count enable per word.

The bidirectional data bus is split into a write-data input, a read-data output and an output-drive flag. The flag goes high only where a real bus would be driven. A static mode input selects how reads return data. With flow-through, the word appears in the cycle after the read edge. With pipelined, it appears one cycle later through an extra output register. The output enable acts without waiting for a clock and can float the bus at any time. The counter does not depend on the chip selects, so address sequencing goes on while the port is deselected.

Top module: `sbsram_port`

## Requirements
- R1: At a rising edge where sel_n=0, sel=1 and rd_wr=0, wdata is written into the word at the address the counter takes at that same edge.
- R2: With pipe_mode=0, a read is registered at an edge where sel_n=0, sel=1 and rd_wr=1. For the whole following cycle, rdata equals the word at the counter's new address and rdata_oe=1, unless oe_n=1.
- R3: With pipe_mode=1, the same read returns its word and raises rdata_oe one cycle later than in R2. The word returned is the word as stored at the address the counter took at the read edge.
- R4: An edge with sel_n=1 or sel=0 performs no write and leaves rdata_oe=0. This lasts for the next cycle with pipe_mode=0, and for the cycle after that with pipe_mode=1.
- R5: While oe_n=1, rdata_oe=0 at once, with no clock edge needed.
- R6: At an edge with cnt_clr_n=0, the counter becomes 0 whatever load_n and cnt_en_n are.
- R7: At an edge with cnt_clr_n=1 and load_n=0, the counter takes addr_in.
- R8: At an edge with cnt_clr_n=1, load_n=1 and cnt_en_n=1, the counter keeps its value and addr_in has no effect.
- R9: At an edge with cnt_clr_n=1, load_n=1 and cnt_en_n=0, the counter advances by one and wraps from the top address to 0.
- R10: The counter follows R6 to R9 in the same way while the port is deselected.
- R11: While rst_n=0, the counter is 0 and rdata_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static read mode: 0 flow-through, 1 pipelined |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| rd_wr | input | 1 | 1 read, 0 write |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr_in | input | ADDR_W | External address for counter load |
| load_n | input | 1 | Active-low counter load |
| cnt_en_n | input | 1 | Active-low counter advance |
| cnt_clr_n | input | 1 | Active-low counter clear |
| wdata | input | DATA_W | Write data (bus input side) |
| rdata | output | DATA_W | Read data (bus output side) |
| rdata_oe | output | 1 | High where the bus would be driven |

## Verification
Counter changes and writes take effect at the edge where they are sampled. A flow-through read is due in the cycle that edge opens, and a pipelined read one cycle later. Deselection follows the same delays. The bench drives each cycle's inputs at the falling edge and advances its reference model at the rising edge. At the next falling edge it compares rdata_oe and, while the flag is high, rdata. This way every result is sampled in the cycle it is due. The output-enable check instead changes oe_n between edges and samples after a short delay, with no edge in between.

// File: rtl/sbsram_port.sv
module sbsram_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              rd_wr,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              load_n,
  input  logic              cnt_en_n,
  input  logic              cnt_clr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pipe_q;
  logic [ADDR_W-1:0] ctr, ctr_nx;
  logic              rd_q1, rd_q2;

  wire selected = sel & ~sel_n;

  always_comb begin
    if (!cnt_clr_n)     ctr_nx = '0;
    else if (!load_n)   ctr_nx = addr_in;
    else if (!cnt_en_n) ctr_nx = ctr + 1'b1;
    else                ctr_nx = ctr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr    <= '0;
      rd_q1  <= 1'b0;
      rd_q2  <= 1'b0;
      pipe_q <= '0;
    end else begin
      ctr    <= ctr_nx;
      rd_q1  <= selected & rd_wr;
      rd_q2  <= rd_q1;
      pipe_q <= mem[ctr];
    end
  end

  always_ff @(posedge clk)
    if (selected && !rd_wr) mem[ctr_nx] <= wdata;

  assign rdata    = pipe_mode ? pipe_q : mem[ctr];
  assign rdata_oe = ~oe_n & (pipe_mode ? rd_q2 : rd_q1);
endmodule

// File: rtl/sbsram_port_chk.sv
module sbsram_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              sel_n,
  input logic              sel,
  input logic              rd_wr,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              load_n,
  input logic              cnt_en_n,
  input logic              cnt_clr_n,
  input logic              rdata_oe,
  input logic [ADDR_W-1:0] ctr
);
  // R6
  clr_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_n |=> ctr == '0);
  // R7
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_n && !load_n |=> ctr == $past(addr_in));
  // R8
  hold_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_n && load_n && cnt_en_n |=> $stable(ctr));
  // R9
  incr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_n && load_n && !cnt_en_n |=> ctr == ADDR_W'($past(ctr) + 1'b1));
  // R5
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);
  // R4
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && (sel_n || !sel) |=> !rdata_oe);
  // R4
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode && (sel_n || !sel) |=> ##1 !rdata_oe);
  // R2
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode && sel && !sel_n && rd_wr |=> rdata_oe || oe_n);
  // R3
  pipe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode && sel && !sel_n && rd_wr |=> ##1 (rdata_oe || oe_n));
endmodule

bind sbsram_port sbsram_port_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel_n(sel_n), .sel(sel),
  .rd_wr(rd_wr), .oe_n(oe_n), .addr_in(addr_in), .load_n(load_n),
  .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .rdata_oe(rdata_oe), .ctr(ctr)
);

// File: tb/sbsram_port_tb.sv
module sbsram_port_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, pipe_mode = 0, sel_n = 1, sel = 0, rd_wr = 1, oe_n = 0;
  logic load_n = 1, cnt_en_n = 1, cnt_clr_n = 1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_oe;

  int checks = 0, fails = 0;

  logic [DW-1:0] mref [DEPTH];
  int  mctr = 0;
  bit  rdq1 = 0, rdq2 = 0;
  logic [DW-1:0] dpipe = '0;

  always #(PERIOD/2) clk = ~clk;

  sbsram_port #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel_n(sel_n), .sel(sel),
    .rd_wr(rd_wr), .oe_n(oe_n), .addr_in(addr_in), .load_n(load_n),
    .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe));

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 7 + 3 + salt) % (1 << DW));
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit eoe = !oe_n && (pipe_mode ? rdq2 : rdq1);
    check(tag, DW'(rdata_oe), DW'(eoe));
    if (eoe) check(tag, rdata, pipe_mode ? dpipe : mref[mctr]);
  endtask

  // one clock: cs_n/cs select, rw, clear/load/enable controls
  task automatic step(string tag, bit cs_n, bit cs, bit rw, bit clr_n, bit ld_n,
                      bit en_n, int a, logic [DW-1:0] wd);
    int eff;
    sel_n = cs_n; sel = cs; rd_wr = rw; cnt_clr_n = clr_n; load_n = ld_n;
    cnt_en_n = en_n; addr_in = AW'(a); wdata = wd;
    @(posedge clk);
    eff = !clr_n ? 0 : !ld_n ? a : !en_n ? (mctr + 1) % DEPTH : mctr;
    dpipe = mref[mctr];
    if (!cs_n && cs && !rw) mref[eff] = wd;
    rdq2 = rdq1;
    rdq1 = !cs_n && cs && rw;
    mctr = eff;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1, 0, 1, 1, 1, 1, 0, '0);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    mctr = 0; rdq1 = 0; rdq2 = 0; dpipe = '0;
    check("R11", DW'(rdata_oe), '0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic read_burst(string tag, int start, int n);
    step(tag, 0, 1, 1, 1, 0, 1, start, '0);
    for (int i = 1; i < n; i++) step(tag, 0, 1, 1, 1, 1, 0, (i * 37) % DEPTH, '0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R11", DW'(rdata_oe), '0);
    rst_n = 1;
    @(negedge clk);

    // fill with a burst write: load then increment, then wrap onto 0
    step("R1", 0, 1, 0, 1, 0, 1, 0, pat(0, 0));
    for (int a = 1; a < DEPTH; a++) step("R9", 0, 1, 0, 1, 1, 0, 0, pat(a, 0));
    step("R9", 0, 1, 0, 1, 1, 0, 0, pat(0, 5));

    // flow-through reads across the wrap point
    read_burst("R2", 250, 12);
    // hold while the external address changes
    for (int i = 0; i < 4; i++) step("R8", 0, 1, 1, 1, 1, 1, i * 51, '0);
    // clear wins over load and increment
    step("R6", 0, 1, 1, 0, 0, 0, 77, '0);
    step("R6", 0, 1, 1, 1, 1, 1, 0, '0);
    // load an address and read it
    step("R7", 0, 1, 1, 1, 0, 1, 130, '0);
    // counter runs while deselected by either select
    step("R10", 1, 1, 1, 1, 0, 1, 40, '0);
    step("R10", 1, 1, 1, 1, 1, 0, 0, '0);
    step("R10", 0, 0, 1, 1, 1, 0, 0, '0);
    step("R10", 0, 1, 1, 1, 1, 1, 0, '0);
    // deselected write attempts leave memory untouched
    step("R4", 0, 0, 0, 1, 0, 1, 5, 9'h000);
    step("R4", 1, 1, 0, 1, 1, 1, 0, 9'h000);
    step("R4", 0, 1, 1, 1, 1, 1, 0, '0);
    // selected write then read back
    step("R1", 0, 1, 0, 1, 0, 1, 20, 9'h1AA);
    step("R1", 0, 1, 1, 1, 0, 1, 20, '0);
    // output enable floats the bus without a clock edge
    step("R5", 0, 1, 1, 1, 1, 1, 0, '0);
    oe_n = 1;
    #1 check("R5", DW'(rdata_oe), '0);
    oe_n = 0;
    #1 check("R5", DW'(rdata_oe), 9'd1);
    oe_n = 1;
    step("R5", 0, 1, 1, 1, 1, 0, 0, '0);
    oe_n = 0;
    #1 check("R5", DW'(rdata_oe), 9'd1);

    // reset returns the counter to 0
    step("R11", 0, 1, 1, 1, 0, 1, 99, '0);
    pulse_reset();
    step("R11", 0, 1, 1, 1, 1, 1, 0, '0);
    check("R11", rdata, mref[0]);

    // pipelined mode
    idle("R4", 2);
    pipe_mode = 1;
    idle("R4", 2);
    read_burst("R3", 250, 12);
    step("R3", 0, 1, 1, 1, 0, 1, 20, '0);
    step("R4", 1, 1, 1, 1, 0, 1, 60, '0);
    step("R4", 0, 1, 1, 1, 0, 1, 61, '0);
    step("R4", 0, 0, 1, 1, 0, 1, 62, '0);
    step("R4", 0, 1, 1, 1, 0, 1, 63, '0);
    step("R4", 1, 0, 1, 1, 1, 0, 0, '0);
    // read then write the same word back to back
    step("R3", 0, 1, 1, 1, 0, 1, 90, '0);
    step("R3", 0, 1, 0, 1, 1, 1, 0, 9'h055);
    step("R3", 0, 1, 1, 1, 1, 1, 0, '0);
    idle("R3", 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule